// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Partial Flags

This block buffers 36-bit words from a write port to a read port, each port on its own free-running clock. The two clocks may be unrelated or may be the same clock. Each pointer crosses to the other domain in Gray code through a two-stage synchronizer. As a result, the empty and full indications can clear a few cycles late but never early. At full reset, a timing pin selects one of two flag modes. In standard mode the read-side flag reports empty, the write-side flag reports full, and a read request is needed to present each word. In fall-through mode the first word moves to the output by itself, the read-side flag reports that the output holds valid data, and the write-side flag reports that a write is accepted.

Two partial flags give early warning near each end of the buffer. Each flag compares against its own offset. At full reset a 2-bit select chooses the offsets: 8, 16 or 64 words, or user programming. User offsets are loaded either one bit per write clock on a serial input, or through the first two data writes. A full reset clears the data and reloads the whole configuration. A partial reset clears only the data and keeps the mode and the offsets.

Top module: `dcff_top`

## Requirements
- R1: Words are read out in the order written, with all 36 bits intact. The depth parameter DEPTH is 256, 512 or 1024.
- R2: In standard mode `rd_flag`=1 means empty and `wr_flag`=1 means full. A write while full and a read while empty change neither the stored data, the pointers nor `dout`.
- R3: In fall-through mode, after reset `rd_flag`=0 and `wr_flag`=1. The first word written appears on `dout` and raises `rd_flag` with no read request. Each read pulse moves the next word onto `dout`, and `dout` is held while no read is requested.
- R4: At full reset `ofs_sel` selects both offsets: 2'b00 selects 8, 2'b01 selects 16 and 2'b10 selects 64. 2'b11 selects user programming, in which case both offsets read as zero until they are loaded.
- R5: `aempty`=1 exactly when the stored word count is at or below the empty offset. `afull`=1 exactly when the free space (DEPTH minus count) is at or below the full offset. In fall-through mode the word on `dout` is included in the count used for `aempty`.
- R6: With `ofs_sel`=2'b11 and `ser_prog`=1, one bit of `sdin` is taken on each write clock while `sen`=1. The empty offset comes first, then the full offset, each least significant bit first, log2(DEPTH) bits each. Until all bits have arrived, `wr_flag` reports no room and writes are ignored.
- R7: With `ofs_sel`=2'b11 and `ser_prog`=0, the first write after full reset loads the empty offset from `din[log2(DEPTH)-1:0]`, and the second write loads the full offset. Neither write is stored, and later writes store data.
- R8: Full reset (`rst_n`=0) empties the FIFO and reloads the mode and the offsets. Partial reset (`prst_n`=0) empties the FIFO and keeps the mode and the offsets as they were.
- R9: A read and a write on the same clock edge both take effect. The count is unchanged and the data order is kept.
- R10: The write and read pointers cross domains in Gray code, so exactly one bit changes per step. A word written appears as not-empty no earlier than the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, asynchronous |
| fwft_en | input | 1 | Fall-through mode select, sampled during full reset |
| ofs_sel | input | 2 | Offset select, sampled during full reset |
| ser_prog | input | 1 | 1 = serial, 0 = parallel user offset loading |
| wen | input | 1 | Write request |
| din | input | 36 | Write data |
| sen | input | 1 | Serial offset bit enable |
| sdin | input | 1 | Serial offset bit |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| afull | output | 1 | Almost-full flag |
| ren | input | 1 | Read request |
| dout | output | 36 | Read data |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| aempty | output | 1 | Almost-empty flag |

## Verification
The bench builds the block with DEPTH=256. At that depth, filling to full and draining to empty take only a few hundred cycles, and all three preset offsets sit well inside the buffer, so each threshold can be approached from both sides. Both ports run from one clock. This makes the synchronizer delay a fixed number of cycles, so the same-edge read-and-write case and the late clearing of empty can be checked in exact cycles. Serial and parallel user offsets are chosen small (5/3 and 10/20), so the boundaries on either side of each programmed value stay cheap to reach.

// File: rtl/dcff_pkg.sv
package dcff_pkg;
  localparam int unsigned WORD_W = 36;

  typedef enum logic [1:0] {
    SEL_OFS8  = 2'b00,
    SEL_OFS16 = 2'b01,
    SEL_OFS64 = 2'b10,
    SEL_USER  = 2'b11
  } ofs_sel_e;

  localparam int unsigned OFS_SMALL = 8;
  localparam int unsigned OFS_MID   = 16;
  localparam int unsigned OFS_LARGE = 64;
endpackage

// File: rtl/dcff_rst_sync.sv
module dcff_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dcff_ptr_sync.sv
module dcff_ptr_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  // Gray to binary: running XOR from the top bit down
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ s2_q[i];
      bin_out[i] = acc;
    end
  end
endmodule

// File: rtl/dcff_mem.sv
module dcff_mem #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned N = 1 << AW;

  logic [DW-1:0] store_q [N];

  always_ff @(posedge wclk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/dcff_wr_ctl.sv
module dcff_wr_ctl
  import dcff_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          wclk,
  input  logic          w_rst_n,
  input  logic          w_cfg_n,
  input  logic [1:0]    ofs_sel,
  input  logic          ser_prog,
  input  logic          fwft_en,
  input  logic          wen,
  input  logic [AW-1:0] prog_data,
  input  logic          sen,
  input  logic          sdin,
  input  logic [AW:0]   rbin_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          w_full,
  output logic          prog_done,
  output logic          wr_flag,
  output logic          afull,
  output logic [AW-1:0] ae_off
);
  localparam int unsigned SBITS = 2 * AW;
  localparam int unsigned PCW   = $clog2(SBITS + 1);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  // configuration state (loaded while full reset is held)
  logic          fwft_q, fwft_d;
  logic          ser_q, ser_d;
  logic          done_q, done_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [AW-1:0] ae_q, ae_d, af_q, af_d;

  // data-path state
  logic [AW:0]   wbin_d, wgray_d, wfill, wfree;
  logic          push;
  logic [SBITS:0] shift_w;

  assign wfill   = wbin - rbin_sync;
  assign wfree   = DEPTH_V - wfill;
  assign w_full  = (wfill == DEPTH_V) || !done_q;
  assign push    = wen && !w_full;
  assign wbin_d  = wbin + {{AW{1'b0}}, push};
  assign wgray_d = wbin_d ^ (wbin_d >> 1);
  assign shift_w = {sdin, af_q, ae_q};

  always_comb begin
    fwft_d = fwft_q;
    ser_d  = ser_q;
    done_d = done_q;
    pcnt_d = pcnt_q;
    ae_d   = ae_q;
    af_d   = af_q;
    if (!w_cfg_n) begin
      fwft_d = fwft_en;
      ser_d  = ser_prog;
      pcnt_d = '0;
      done_d = (ofs_sel != SEL_USER);
      case (ofs_sel)
        SEL_OFS8:  ae_d = AW'(OFS_SMALL);
        SEL_OFS16: ae_d = AW'(OFS_MID);
        SEL_OFS64: ae_d = AW'(OFS_LARGE);
        default:   ae_d = '0;
      endcase
      af_d = ae_d;
    end else if (w_rst_n && !done_q && ser_q && sen) begin
      {af_d, ae_d} = shift_w[SBITS:1];
      pcnt_d       = pcnt_q + PCW'(1);
      if (pcnt_q == PCW'(SBITS - 1)) done_d = 1'b1;
    end else if (w_rst_n && !done_q && !ser_q && wen) begin
      if (pcnt_q == '0) begin
        ae_d = prog_data;
      end else begin
        af_d   = prog_data;
        done_d = 1'b1;
      end
      pcnt_d = pcnt_q + PCW'(1);
    end
  end

  always_ff @(posedge wclk) begin
    fwft_q <= fwft_d;
    ser_q  <= ser_d;
    done_q <= done_d;
    pcnt_q <= pcnt_d;
    ae_q   <= ae_d;
    af_q   <= af_d;
  end

  always_ff @(posedge wclk or negedge w_rst_n) begin
    if (!w_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_d;
      wgray <= wgray_d;
    end
  end

  assign mem_we    = push;
  assign mem_waddr = wbin[AW-1:0];
  assign prog_done = done_q;
  assign wr_flag   = fwft_q ? !w_full : w_full;
  assign afull     = wfree <= {1'b0, af_q};
  assign ae_off    = ae_q;
endmodule

// File: rtl/dcff_rd_ctl.sv
module dcff_rd_ctl #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 36
) (
  input  logic          rclk,
  input  logic          r_rst_n,
  input  logic          r_cfg_n,
  input  logic          fwft_en,
  input  logic          ren,
  input  logic [AW:0]   wbin_sync,
  input  logic [AW-1:0] ae_off,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          r_empty,
  output logic          fwft_q,
  output logic          or_q,
  output logic          rd_flag,
  output logic          aempty
);
  logic [AW:0]   rfill, level, rbin_d, rgray_d;
  logic [DW-1:0] dout_d;
  logic          pull, or_d;

  assign rfill   = wbin_sync - rbin;
  assign r_empty = (rfill == '0);

  always_comb begin
    pull    = !r_empty && (fwft_q ? (!or_q || ren) : ren);
    rbin_d  = rbin + {{AW{1'b0}}, pull};
    rgray_d = rbin_d ^ (rbin_d >> 1);
    dout_d  = pull ? mem_rdata : dout;
    or_d    = fwft_q ? (pull || (or_q && !ren)) : 1'b0;
  end

  always_ff @(posedge rclk) begin
    if (!r_cfg_n) fwft_q <= fwft_en;
  end

  always_ff @(posedge rclk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      dout  <= '0;
      or_q  <= 1'b0;
    end else begin
      rbin  <= rbin_d;
      rgray <= rgray_d;
      dout  <= dout_d;
      or_q  <= or_d;
    end
  end

  assign level     = rfill + {{AW{1'b0}}, or_q};
  assign aempty    = level <= {1'b0, ae_off};
  assign rd_flag   = fwft_q ? or_q : r_empty;
  assign mem_raddr = rbin[AW-1:0];
endmodule

// File: rtl/dcff_top.sv
module dcff_top
  import dcff_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = WORD_W
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          prst_n,
  input  logic          fwft_en,
  input  logic [1:0]    ofs_sel,
  input  logic          ser_prog,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          sen,
  input  logic          sdin,
  output logic          wr_flag,
  output logic          afull,
  input  logic          ren,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          aempty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          data_arst_n;
  logic [3:0]    rs_src, rs_out;
  logic          w_rst_n, w_cfg_n, r_rst_n, r_cfg_n;
  logic [AW:0]   wbin, wgray, rbin, rgray, wbin_sync, rbin_sync;
  logic          mem_we, w_full, prog_done, r_empty, fwft_q, or_q;
  logic [AW-1:0] mem_waddr, mem_raddr, ae_off;
  logic [DW-1:0] mem_rdata;

  // bit 0: write data, 1: write config, 2: read data, 3: read config
  assign data_arst_n = rst_n & prst_n;
  assign rs_src      = {rst_n, data_arst_n, rst_n, data_arst_n};

  for (genvar g = 0; g < 4; g++) begin : g_rsync
    dcff_rst_sync #(.STAGES(2)) u_rs (
      .clk    ((g < 2) ? wclk : rclk),
      .arst_n (rs_src[g]),
      .rst_n  (rs_out[g])
    );
  end

  assign w_rst_n = rs_out[0];
  assign w_cfg_n = rs_out[1];
  assign r_rst_n = rs_out[2];
  assign r_cfg_n = rs_out[3];

  dcff_ptr_sync #(.W(AW + 1)) u_r2w (
    .clk (wclk), .rst_n (w_rst_n), .gray_in (rgray), .bin_out (rbin_sync)
  );

  dcff_ptr_sync #(.W(AW + 1)) u_w2r (
    .clk (rclk), .rst_n (r_rst_n), .gray_in (wgray), .bin_out (wbin_sync)
  );

  dcff_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk  (wclk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (din),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  dcff_wr_ctl #(.AW(AW)) u_wr (
    .wclk      (wclk),
    .w_rst_n   (w_rst_n),
    .w_cfg_n   (w_cfg_n),
    .ofs_sel   (ofs_sel),
    .ser_prog  (ser_prog),
    .fwft_en   (fwft_en),
    .wen       (wen),
    .prog_data (din[AW-1:0]),
    .sen       (sen),
    .sdin      (sdin),
    .rbin_sync (rbin_sync),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .wbin      (wbin),
    .wgray     (wgray),
    .w_full    (w_full),
    .prog_done (prog_done),
    .wr_flag   (wr_flag),
    .afull     (afull),
    .ae_off    (ae_off)
  );

  dcff_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .rclk      (rclk),
    .r_rst_n   (r_rst_n),
    .r_cfg_n   (r_cfg_n),
    .fwft_en   (fwft_en),
    .ren       (ren),
    .wbin_sync (wbin_sync),
    .ae_off    (ae_off),
    .mem_rdata (mem_rdata),
    .mem_raddr (mem_raddr),
    .rbin      (rbin),
    .rgray     (rgray),
    .dout      (dout),
    .r_empty   (r_empty),
    .fwft_q    (fwft_q),
    .or_q      (or_q),
    .rd_flag   (rd_flag),
    .aempty    (aempty)
  );
endmodule

// File: rtl/dcff_chk.sv
module dcff_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 36
) (
  input logic          wclk,
  input logic          rclk,
  input logic          w_rst_n,
  input logic          r_rst_n,
  input logic          w_full,
  input logic          prog_done,
  input logic          fwft_q,
  input logic          or_q,
  input logic          r_empty,
  input logic          ren,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rbin,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] dout
);
  // R10: Gray pointers step by at most one bit per clock
  a_r10_wgray_step: assert property (@(posedge wclk) disable iff (!w_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r10_rgray_step: assert property (@(posedge rclk) disable iff (!r_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R2: no write pointer advance while full
  a_r2_no_overflow: assert property (@(posedge wclk) disable iff (!w_rst_n)
    w_full |=> $stable(wbin));

  // R2: no read pointer advance while empty
  a_r2_no_underflow: assert property (@(posedge rclk) disable iff (!r_rst_n)
    r_empty |=> $stable(rbin));

  // R3: presented word held until read
  a_r3_or_hold: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (fwft_q && or_q && !ren) |=> (or_q && $stable(dout)));

  // R6: nothing is stored before offset programming completes
  a_r6_prog_gate: assert property (@(posedge wclk) disable iff (!w_rst_n)
    !prog_done |=> $stable(wbin));
endmodule

bind dcff_top dcff_chk #(.AW(AW), .DW(DW)) chk_i (
  .wclk      (wclk),
  .rclk      (rclk),
  .w_rst_n   (w_rst_n),
  .r_rst_n   (r_rst_n),
  .w_full    (w_full),
  .prog_done (prog_done),
  .fwft_q    (fwft_q),
  .or_q      (or_q),
  .r_empty   (r_empty),
  .ren       (ren),
  .wbin      (wbin),
  .wgray     (wgray),
  .rbin      (rbin),
  .rgray     (rgray),
  .dout      (dout)
);

// File: tb/dcff_top_tb_top.sv
module dcff_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int SETTLE     = 6;
  localparam int NVEC       = 9;

  // vector: [31] 1=read burst, [30:20] word count, [3:0] {rd_flag,wr_flag,aempty,afull}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b0, 11'd16,  16'd0, 4'b0010},
    {1'b0, 11'd1,   16'd0, 4'b0000},
    {1'b0, 11'd222, 16'd0, 4'b0000},
    {1'b0, 11'd1,   16'd0, 4'b0001},
    {1'b0, 11'd16,  16'd0, 4'b0101},
    {1'b1, 11'd1,   16'd0, 4'b0001},
    {1'b1, 11'd238, 16'd0, 4'b0000},
    {1'b1, 11'd1,   16'd0, 4'b0010},
    {1'b1, 11'd16,  16'd0, 4'b1010}
  };

  logic        clk;
  logic        rst_n, prst_n, fwft_en, ser_prog, wen, sen, sdin, ren;
  logic [1:0]  ofs_sel;
  logic [35:0] din, dout, held;
  logic        wr_flag, afull, rd_flag, aempty;

  int n_chk, n_fail, wr_seq, rd_seq;
  bit finished;

  dcff_top #(.DEPTH(DEPTH)) dut_i (
    .wclk (clk), .rclk (clk), .rst_n (rst_n), .prst_n (prst_n),
    .fwft_en (fwft_en), .ofs_sel (ofs_sel), .ser_prog (ser_prog),
    .wen (wen), .din (din), .sen (sen), .sdin (sdin),
    .wr_flag (wr_flag), .afull (afull), .ren (ren), .dout (dout),
    .rd_flag (rd_flag), .aempty (aempty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [35:0] pat(int n);
    return {4'hC, 32'(n * 3 + 1)};
  endfunction

  task automatic chk36(string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk4(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {rd_flag, wr_flag, aempty, afull};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: flags {rd,wr,ae,af} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic do_reset(bit full, bit fw, logic [1:0] sel, bit ser);
    @(negedge clk);
    fwft_en = fw; ofs_sel = sel; ser_prog = ser;
    if (full) rst_n = 1'b0; else prst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; prst_n = 1'b1;
    repeat (5) @(negedge clk);
    wr_seq = 0; rd_seq = 0;
  endtask

  task automatic raw_write(logic [35:0] val);
    @(negedge clk); wen = 1'b1; din = val;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic wr_burst(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wen = 1'b1; din = pat(wr_seq); wr_seq++;
    end
    @(negedge clk); wen = 1'b0;
    settle();
  endtask

  task automatic rd_burst(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ren = 1'b1;
      if (i > 0) begin chk36("R1 read order", dout, pat(rd_seq)); rd_seq++; end
    end
    @(negedge clk); ren = 1'b0;
    chk36("R1 read order", dout, pat(rd_seq)); rd_seq++;
    settle();
  endtask

  task automatic shift_bits(logic [7:0] val);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); sen = 1'b1; sdin = val[b];
    end
    @(negedge clk); sen = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; prst_n = 1'b1; fwft_en = 1'b0; ofs_sel = 2'b01; ser_prog = 1'b0;
    wen = 1'b0; ren = 1'b0; sen = 1'b0; sdin = 1'b0; din = '0;
    n_chk = 0; n_fail = 0; finished = 0;

    // standard mode, offset 16: reset state
    do_reset(1, 0, 2'b01, 0);
    chk4("R8 reset state standard", 4'b1010);

    // table walk: fill to full, drain to empty (R5 thresholds, R2 full/empty)
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][31]) rd_burst(int'(VEC[v][30:20]));
      else            wr_burst(int'(VEC[v][30:20]));
      chk4($sformatf("R5 vector %0d", v), VEC[v][3:0]);
    end

    // R9: read and write on the same edge
    wr_burst(4);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); wen = 1'b1; ren = 1'b1; din = pat(wr_seq); wr_seq++;
      if (i > 0) begin chk36("R9 same-edge data", dout, pat(rd_seq)); rd_seq++; end
    end
    @(negedge clk); wen = 1'b0; ren = 1'b0;
    chk36("R9 same-edge data", dout, pat(rd_seq)); rd_seq++;
    settle();
    chk4("R9 count unchanged", 4'b0010);
    rd_burst(4);
    chk4("R9 drained", 4'b1010);

    // R2: overflow ignored
    wr_burst(DEPTH);
    chk4("R2 full", 4'b0101);
    raw_write(36'hF_FFFF_FFFF); raw_write(36'hF_FFFF_FFFF); raw_write(36'hF_FFFF_FFFF);
    settle();
    chk4("R2 still full after overflow", 4'b0101);
    rd_burst(DEPTH);
    chk4("R2 empty after drain", 4'b1010);

    // R2: underflow ignored
    held = dout;
    @(negedge clk); ren = 1'b1;
    @(negedge clk); ren = 1'b0;
    settle();
    chk36("R2 dout held on empty read", dout, held);
    chk4("R2 still empty", 4'b1010);

    // R10: empty clears late, never early
    @(negedge clk); wen = 1'b1; din = pat(wr_seq); wr_seq++;
    @(negedge clk); wen = 1'b0;
    n_chk++;
    if (rd_flag !== 1'b1) begin
      n_fail++;
      $display("FAIL R10 empty cleared early: actual %b expected 1", rd_flag);
    end
    settle();
    rd_burst(1);

    // R4/R5: preset 64
    do_reset(1, 0, 2'b10, 0);
    wr_burst(64);
    chk4("R4 offset 64 ae at 64", 4'b0010);
    wr_burst(1);
    chk4("R4 offset 64 ae clear at 65", 4'b0000);
    wr_burst(126);
    chk4("R5 free 65 af clear", 4'b0000);
    wr_burst(1);
    chk4("R5 free 64 af set", 4'b0001);

    // R3: fall-through mode, preset 8
    do_reset(1, 1, 2'b00, 0);
    chk4("R3 reset state fwft", 4'b0110);
    wr_burst(1);
    chk4("R3 output ready without read", 4'b1110);
    chk36("R3 first word presented", dout, pat(0));
    wr_burst(7);
    chk4("R4 offset 8 ae at 8", 4'b1110);
    wr_burst(1);
    chk4("R4 offset 8 ae clear at 9", 4'b1100);
    @(negedge clk); ren = 1'b1;
    @(negedge clk); ren = 1'b0;
    chk36("R3 next word after read", dout, pat(1));
    settle();
    chk36("R3 dout held without read", dout, pat(1));
    chk4("R5 fwft count incl output", 4'b1110);

    // R6: serial programming, ae=5, af=3
    do_reset(1, 0, 2'b11, 1);
    chk4("R6 blocked before programming", 4'b1110);
    raw_write(36'h0_DEAD_BEEF);
    settle();
    chk4("R6 write ignored before programming", 4'b1110);
    shift_bits(8'd5);
    shift_bits(8'd3);
    settle();
    chk4("R6 programmed empty", 4'b1010);
    wr_burst(5);
    chk4("R6 ae at 5", 4'b0010);
    wr_burst(1);
    chk4("R6 ae clear at 6", 4'b0000);
    wr_burst(247);
    chk4("R6 af at free 3", 4'b0001);
    rd_burst(1);
    chk4("R6 af clear at free 4", 4'b0000);

    // R7: parallel programming, ae=10, af=20
    do_reset(1, 0, 2'b11, 0);
    raw_write(36'd10);
    raw_write(36'd20);
    settle();
    chk4("R7 program writes not stored", 4'b1010);
    wr_burst(10);
    chk4("R7 ae at 10", 4'b0010);
    wr_burst(1);
    chk4("R7 ae clear at 11", 4'b0000);
    rd_burst(1);

    // R8: partial reset keeps offsets, full reset reloads
    do_reset(0, 0, 2'b11, 0);
    chk4("R8 partial reset empties", 4'b1010);
    wr_burst(10);
    chk4("R8 offset kept after partial reset", 4'b0010);
    wr_burst(1);
    chk4("R8 offset kept ae clear", 4'b0000);
    rd_burst(1);
    do_reset(1, 0, 2'b01, 0);
    chk4("R8 full reset empties", 4'b1010);
    wr_burst(16);
    chk4("R8 full reset reloads offset 16", 4'b0010);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule